// File: doc/BRIEF.md
# Dual-Rail Power-Good Supervisor

This block decides whether a controller with two regulated outputs may report power good. Each rail has an in-window flag from an external window comparator. The block reports good only after both flags have been high together for a long qualification time. It reports not-good only after a fault has lasted through a shorter filter time, so brief excursions count as glitches. Its output drives the pull-down of an open-drain status pin.

Taking the converter enable low sets not-good at once, through a purely combinational path that bypasses both filters. The same condition drives a bleeder-enable output, which discharges the output capacitors gradually. All delays are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. Each conversion is rounded up.

Top module: `pgood_supervisor`

## Requirements
- R1: Good is reported only when both `rail_a_ok` and `rail_b_ok` are high at the same time. One good rail never qualifies.
- R2: Once good, the block reports not-good when at least one rail flag has been low for FAULT_CYC consecutive sampled cycles. A shorter excursion leaves the output at good.
- R3: While not-good and enabled, the block reports good after both flags have been high for GOOD_CYC consecutive sampled cycles.
- R4: When `enable` is low, `pgood_pd_n` is 0 in the same cycle, with no clock edge needed.
- R5: Output encoding: `pgood_pd_n` = 1 releases the pin (good). `pgood_pd_n` = 0 turns the pull-down on (not-good).
- R6: `bleed_en` is 1 exactly while `enable` is 0.
- R7: A dropout of a single cycle in the qualifying condition restarts that delay from zero. This holds for both delays.
- R8: After reset, `pgood_pd_n` is 0 and both delay counts are cleared.
- R9: After `enable` returns high, good requires the full GOOD_CYC qualification again.
- R10: FAULT_CYC = ceil(FAULT_NS·CLK_HZ/1e9) and GOOD_CYC = ceil(GOOD_NS·CLK_HZ/1e9). At the defaults (100 MHz, 7000 ns, 20000 ns) these are 700 and 2000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low forces not-good |
| rail_a_ok | input | 1 | Rail A in-window flag |
| rail_b_ok | input | 1 | Rail B in-window flag |
| pgood_pd_n | output | 1 | Active-low pull-down control (1 = good, pin released) |
| bleed_en | output | 1 | Output-capacitor bleeder enable |

## Verification
Rail flags are sampled at rising edges. The good/not-good state changes at the edge that samples the GOOD_CYC-th consecutive in-window cycle, or the FAULT_CYC-th consecutive out-of-window cycle. The bench drives inputs at falling edges. It advances a reference model at each rising edge and compares `pgood_pd_n` and `bleed_en` at the next falling edge, so every change is checked in the cycle it becomes due. The disable path has no register. It is therefore checked 1 ns after `enable` falls, in the middle of a low clock phase. Directed holds of GOOD_CYC-1 and GOOD_CYC cycles, and of FAULT_CYC-1 and FAULT_CYC cycles, pin down the boundaries.

// File: rtl/pgood_supervisor.sv
module pgood_supervisor #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned FAULT_NS = 7_000,
  parameter int unsigned GOOD_NS  = 20_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic rail_a_ok,
  input  logic rail_b_ok,
  output logic pgood_pd_n,
  output logic bleed_en
);
  localparam longint unsigned GIGA  = 64'd1_000_000_000;
  localparam longint unsigned F_RAW = (64'(FAULT_NS) * 64'(CLK_HZ) + GIGA - 64'd1) / GIGA;
  localparam longint unsigned G_RAW = (64'(GOOD_NS) * 64'(CLK_HZ) + GIGA - 64'd1) / GIGA;
  localparam int unsigned FAULT_CYC = (F_RAW == 0) ? 1 : int'(F_RAW);
  localparam int unsigned GOOD_CYC  = (G_RAW == 0) ? 1 : int'(G_RAW);
  localparam int unsigned MAX_CYC   = (GOOD_CYC > FAULT_CYC) ? GOOD_CYC : FAULT_CYC;
  localparam int unsigned CW        = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] FAULT_LAST = CW'(FAULT_CYC - 1);
  localparam logic [CW-1:0] GOOD_LAST  = CW'(GOOD_CYC - 1);

  logic          good_q;
  logic [CW-1:0] good_cnt;
  logic [CW-1:0] flt_cnt;
  logic          both_ok;

  assign both_ok    = rail_a_ok & rail_b_ok;
  assign pgood_pd_n = good_q & enable;
  assign bleed_en   = ~enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q   <= 1'b0;
      good_cnt <= '0;
      flt_cnt  <= '0;
    end else if (!enable) begin
      good_q   <= 1'b0;
      good_cnt <= '0;
      flt_cnt  <= '0;
    end else if (!good_q) begin
      flt_cnt <= '0;
      if (!both_ok) begin
        good_cnt <= '0;
      end else if (good_cnt == GOOD_LAST) begin
        good_cnt <= '0;
        good_q   <= 1'b1;
      end else begin
        good_cnt <= good_cnt + 1'b1;
      end
    end else begin
      good_cnt <= '0;
      if (both_ok) begin
        flt_cnt <= '0;
      end else if (flt_cnt == FAULT_LAST) begin
        flt_cnt <= '0;
        good_q  <= 1'b0;
      end else begin
        flt_cnt <= flt_cnt + 1'b1;
      end
    end
  end

  // R1
  one_rail_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!good_q && !both_ok) |=> !good_q);

  // R2
  fault_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && good_q && flt_cnt < FAULT_LAST) |=> good_q);

  // R3
  good_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!good_q && good_cnt < GOOD_LAST) |=> !good_q);

  // R4
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!good_q && good_cnt == '0 && flt_cnt == '0));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!both_ok && !good_q) |=> good_cnt == '0);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_cnt <= GOOD_LAST && flt_cnt <= FAULT_LAST));
endmodule

// File: tb/pgood_supervisor_bench.sv
`timescale 1ns/1ps
module pgood_supervisor_bench;
  localparam int unsigned FAULT = (7000 * 100 + 999) / 1000;   // R10: 700
  localparam int unsigned GOOD  = (20000 * 100 + 999) / 1000;  // R10: 2000

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0, ra = 1'b0, rb = 1'b0;
  logic pgood_pd_n, bleed_en;
  int errors = 0, checks = 0, cycles = 0;
  int run_ok = 0, run_bad = 0;
  logic exp_good = 1'b0;

  always #5 clk = ~clk;

  pgood_supervisor u_pgood_supervisor (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rail_a_ok(ra), .rail_b_ok(rb),
    .pgood_pd_n(pgood_pd_n), .bleed_en(bleed_en));

  function automatic logic exp_pd(logic g, logic en);
    return g & en;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n || !enable) begin
      exp_good = 1'b0; run_ok = 0; run_bad = 0;
    end else if (!exp_good) begin
      run_bad = 0;
      run_ok = (ra && rb) ? run_ok + 1 : 0;
      if (run_ok >= GOOD) begin exp_good = 1'b1; run_ok = 0; end
    end else begin
      run_ok = 0;
      run_bad = (ra && rb) ? 0 : run_bad + 1;
      if (run_bad >= FAULT) begin exp_good = 1'b0; run_bad = 0; end
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    cycles++;
    @(negedge clk);
    chk(enable ? "R1/R2/R3/R5" : "R4", pgood_pd_n, exp_pd(exp_good, enable));
    chk("R6", bleed_en, ~enable);
  endtask

  task automatic drive(logic en, logic a, logic b, int n);
    logic was_en = enable;
    enable = en; ra = a; rb = b;
    if (was_en && !en) begin
      #1;
      chk("R4", pgood_pd_n, 1'b0);
      chk("R6", bleed_en, 1'b1);
    end
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    enable = 1'b1; ra = 1'b1; rb = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", pgood_pd_n, 1'b0);
    rst_n = 1'b1;
    // R8: counters cleared, so full delay from release
    drive(1, 1, 1, GOOD - 1);
    chk("R10", pgood_pd_n, 1'b0);
    drive(1, 1, 1, 1);
    chk("R10", pgood_pd_n, 1'b1);
    chk("R5", pgood_pd_n, 1'b1);
    // R2: FAULT-1 cycle excursion ignored, FAULT cycles trips
    drive(1, 0, 1, FAULT - 1);
    chk("R2", pgood_pd_n, 1'b1);
    drive(1, 1, 1, 5);
    drive(1, 1, 0, FAULT);
    chk("R2", pgood_pd_n, 1'b0);
    chk("R5", pgood_pd_n, 1'b0);
    // R1: one rail alone never qualifies
    drive(1, 1, 0, GOOD + 50);
    chk("R1", pgood_pd_n, 1'b0);
    // R7: single-cycle dropout restarts good delay
    drive(1, 1, 1, GOOD - 10);
    drive(1, 0, 0, 1);
    drive(1, 1, 1, GOOD - 1);
    chk("R7", pgood_pd_n, 1'b0);
    drive(1, 1, 1, 1);
    chk("R7", pgood_pd_n, 1'b1);
    // R7: single-cycle recovery restarts fault filter
    drive(1, 0, 1, FAULT - 5);
    drive(1, 1, 1, 1);
    drive(1, 0, 1, FAULT - 1);
    chk("R7", pgood_pd_n, 1'b1);
    drive(1, 1, 1, 3);
    // R4 and R9: disable while in regulation, then full re-qualification
    drive(0, 1, 1, 4);
    chk("R4", pgood_pd_n, 1'b0);
    drive(1, 1, 1, GOOD - 1);
    chk("R9", pgood_pd_n, 1'b0);
    drive(1, 1, 1, 1);
    chk("R9", pgood_pd_n, 1'b1);
    // constrained random segments, checked every cycle by the model
    for (int s = 0; s < 50; s++) begin
      int kind = $urandom_range(0, 5);
      case (kind)
        0, 1: drive(1, 1, 1, $urandom_range(GOOD - 3, GOOD + 400));
        2: drive(1, $urandom_range(0, 1), 1'b0, $urandom_range(1, FAULT - 1));
        3: drive(1, 1'b0, $urandom_range(0, 1), $urandom_range(FAULT - 3, FAULT + 200));
        4: drive(0, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(1, 30));
        default: for (int k = 0; k < 40; k++)
          drive(1, $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, $urandom_range(1, 60));
      endcase
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule